// File: doc/BRIEF.md
# Acquisition Sample Packetizer

This block takes acquired samples, one per valid/ready handshake, and breaks each one into a series of 8-bit packets for a byte-wide host link. Every data packet carries a 4-bit slice of the sample, a 3-bit position index and a flag that marks the source as analog or digital. The host uses the index to put the slices back together.

An analog sample is sent with a leading marker byte. The upper nibble of the marker is all ones and its lower nibble names the channel. Data bytes never carry that upper pattern, so the host can always tell a marker from a data byte.

The output drives one of two links. One is a fast path that feeds a USB FIFO. The other is a slow path that feeds a UART transmitter. A select input chooses the link when each sample is accepted. Backpressure from either link stalls the block and never corrupts the stream.

Top module: `samp_packetizer`

## Requirements
- R1: A data byte has the analog flag in bit 7 (1 = analog, 0 = digital), the position index in bits 6:4 and four sample bits in bits 3:0.
- R2: A 12-bit sample produces three data bytes with indices 0, 1 and 2 in that order. The first byte carries bits 11:8, the second bits 7:4 and the last bits 3:0.
- R3: An analog sample is preceded by exactly one marker byte, 0xF0 OR'ed with the 4-bit channel number. A digital sample has no marker, and its channel input has no effect on the output.
- R4: No data byte ever has 1111 in its upper nibble. The index therefore never exceeds 6, and in practice never exceeds 2.
- R5: Sample ready is low from the cycle after a sample is accepted until the last byte of that sample is accepted downstream. Samples are never dropped or interleaved.
- R6: While a link's valid is high and its ready is low, valid stays high and the byte stays unchanged on the next cycle.
- R7: Link select is sampled when a sample is accepted (0 = USB path, 1 = UART path). All bytes of that sample appear only on the chosen link. The other link's valid stays low and its ready has no effect.
- R8: A change of link select while a sample is still being sent does not move any of that sample's bytes to the other link.
- R9: A synchronous active-low reset leaves sample ready high and both link valids low. It discards a partly sent sample, and the next sample starts again at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Block can accept a sample |
| smp_analog | input | 1 | 1 = analog sample, 0 = digital |
| smp_chan | input | 4 | Analog channel number |
| smp_data | input | 12 | Sample word |
| link_sel | input | 1 | 0 = USB path, 1 = UART path |
| usb_valid | output | 1 | Byte available on USB path |
| usb_ready | input | 1 | USB path takes the byte |
| usb_byte | output | 8 | USB path byte |
| uart_valid | output | 1 | Byte available on UART path |
| uart_ready | input | 1 | UART path takes the byte |
| uart_byte | output | 8 | UART path byte |

## Verification
The assertions assume that the sample inputs are stable for as long as valid is offered. They also assume that each link's ready is driven by that link alone. The stall and link assertions rely on the select having been sampled into a register, not read live.

The stimulus follows these assumptions. Inputs change only on falling edges. A sample stays offered until the cycle it is accepted. Each link's ready follows its own mode: always high, a pseudo-random pattern, or held low. A select change in the middle of a sample is done on purpose, to exercise R8.

// File: rtl/pkt_pkg.sv
// Package: shared state encoding and link codes for the sample packetizer.
package pkt_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_DATA} seq_state_t;
    localparam logic LINK_USB  = 1'b0;
    localparam logic LINK_UART = 1'b1;
endpackage

// File: rtl/pkt_sequencer.sv
// pkt_sequencer: accepts one sample, holds it, and steps through the
// marker slot (analog only) and the data slots in order.
// Assumes: DATA_W is a multiple of NIB_W and gives at most 7 slots.
module pkt_sequencer
    import pkt_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int NIB_W  = 4,
    parameter int CHAN_W = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_is_analog,
    input  logic [CHAN_W-1:0] s_chan,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_link,
    output logic [DATA_W-1:0] held_data,
    output logic              held_analog,
    output logic [CHAN_W-1:0] held_chan,
    output logic              held_link,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              emit_marker,
    output logic              emit_valid,
    input  logic              emit_ready
);
    localparam int NIBBLES = DATA_W / NIB_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBBLES - 1);

    seq_state_t state_q;

    // Status outputs decoded from the state.
    always_comb begin
        s_ready     = (state_q == ST_IDLE);
        emit_valid  = (state_q != ST_IDLE);
        emit_marker = (state_q == ST_MARK);
    end

    // Capture the sample and advance through its slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_idx     <= '0;
            held_data   <= '0;
            held_analog <= 1'b0;
            held_chan   <= '0;
            held_link   <= LINK_USB;
        end else begin
            case (state_q)
                ST_IDLE: if (s_valid) begin
                    held_data   <= s_data;
                    held_analog <= s_is_analog;
                    held_chan   <= s_chan;
                    held_link   <= s_link;
                    cur_idx     <= '0;
                    state_q     <= s_is_analog ? ST_MARK : ST_DATA;
                end
                ST_MARK: if (emit_ready) state_q <= ST_DATA;
                ST_DATA: if (emit_ready) begin
                    if (cur_idx == LAST_IDX) begin
                        cur_idx <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        cur_idx <= cur_idx + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit_valid |-> !s_ready);

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (cur_idx <= LAST_IDX && cur_idx != '1));

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && emit_ready && cur_idx != LAST_IDX)
        |=> (cur_idx == $past(cur_idx) + 1'b1));

    // R3
    marker_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_is_analog) |=> emit_marker);

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (s_ready && !emit_valid && cur_idx == '0));
endmodule

// File: rtl/pkt_byte_fmt.sv
// pkt_byte_fmt: builds the output byte from the held sample and slot.
// Marker: all-ones upper field plus channel. Data: flag, index, slice.
// Assumes: the slot index never reaches the all-ones value.
module pkt_byte_fmt #(
    parameter int DATA_W = 12,
    parameter int NIB_W  = 4,
    parameter int CHAN_W = 4,
    parameter int IDX_W  = 3
) (
    input  logic [DATA_W-1:0]        data,
    input  logic                     analog,
    input  logic [CHAN_W-1:0]        chan,
    input  logic [IDX_W-1:0]         idx,
    input  logic                     marker,
    output logic [IDX_W+NIB_W:0]     pkt
);
    localparam int NIBBLES = DATA_W / NIB_W;

    logic [NIB_W-1:0] nib;

    // Select the slice for the current index, most significant first.
    always_comb begin
        nib = '0;
        for (int k = 0; k < NIBBLES; k++) begin
            if (idx == IDX_W'(k)) nib = data[(NIBBLES-1-k)*NIB_W +: NIB_W];
        end
    end

    // Assemble either a marker or a data byte.
    always_comb begin
        if (marker) pkt = {{(IDX_W+1){1'b1}}, NIB_W'(chan)};
        else        pkt = {analog, idx, nib};
    end
endmodule

// File: rtl/pkt_link_mux.sv
// pkt_link_mux: routes the byte stream to the link chosen for the
// current sample and returns that link's ready.
// Assumes: link is held constant for a whole sample.
module pkt_link_mux
    import pkt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              usb_valid,
    input  logic              usb_ready,
    output logic [BYTE_W-1:0] usb_byte,
    output logic              uart_valid,
    input  logic              uart_ready,
    output logic [BYTE_W-1:0] uart_byte
);
    // Gate valids by the chosen link and return its ready.
    always_comb begin
        usb_valid  = in_valid && (link == LINK_USB);
        uart_valid = in_valid && (link == LINK_UART);
        usb_byte   = in_byte;
        uart_byte  = in_byte;
        in_ready   = (link == LINK_UART) ? uart_ready : usb_ready;
    end

    // R6
    usb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_valid && !usb_ready) |=> (usb_valid && $stable(usb_byte)));

    // R6
    uart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_valid && !uart_ready) |=> (uart_valid && $stable(uart_byte)));

    // R8
    link_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_valid && !usb_ready) |=> !uart_valid);

    // R7
    one_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({usb_valid, uart_valid}));
endmodule

// File: rtl/samp_packetizer.sv
// samp_packetizer: top level. Sample handshake in, byte stream out to
// one of two links. Assumes a byte of exactly 1 + IDX_W + NIB_W bits.
module samp_packetizer #(
    parameter int DATA_W = 12,
    parameter int NIB_W  = 4,
    parameter int CHAN_W = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    output logic              smp_ready,
    input  logic              smp_analog,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              link_sel,
    output logic              usb_valid,
    input  logic              usb_ready,
    output logic [7:0]        usb_byte,
    output logic              uart_valid,
    input  logic              uart_ready,
    output logic [7:0]        uart_byte
);
    localparam int BYTE_W = 1 + IDX_W + NIB_W;

    logic [DATA_W-1:0] held_data;
    logic              held_analog;
    logic [CHAN_W-1:0] held_chan;
    logic              held_link;
    logic [IDX_W-1:0]  cur_idx;
    logic              emit_marker;
    logic              emit_valid;
    logic              emit_ready;
    logic [BYTE_W-1:0] pkt;

    pkt_sequencer #(.DATA_W(DATA_W), .NIB_W(NIB_W), .CHAN_W(CHAN_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .s_valid(smp_valid), .s_ready(smp_ready), .s_is_analog(smp_analog),
        .s_chan(smp_chan), .s_data(smp_data), .s_link(link_sel),
        .held_data(held_data), .held_analog(held_analog), .held_chan(held_chan),
        .held_link(held_link), .cur_idx(cur_idx), .emit_marker(emit_marker),
        .emit_valid(emit_valid), .emit_ready(emit_ready)
    );

    pkt_byte_fmt #(.DATA_W(DATA_W), .NIB_W(NIB_W), .CHAN_W(CHAN_W), .IDX_W(IDX_W)) u_fmt (
        .data(held_data), .analog(held_analog), .chan(held_chan),
        .idx(cur_idx), .marker(emit_marker), .pkt(pkt)
    );

    pkt_link_mux #(.BYTE_W(BYTE_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .link(held_link),
        .in_valid(emit_valid), .in_byte(pkt), .in_ready(emit_ready),
        .usb_valid(usb_valid), .usb_ready(usb_ready), .usb_byte(usb_byte),
        .uart_valid(uart_valid), .uart_ready(uart_ready), .uart_byte(uart_byte)
    );

    // R1
    data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_valid && !emit_marker) |-> (pkt[BYTE_W-1] == held_analog));
endmodule

// File: tb/tb_samp_packetizer.sv
`timescale 1ns/1ps
module tb_samp_packetizer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0, smp_analog = 1'b0, link_sel = 1'b0;
    logic [3:0] smp_chan = '0;
    logic [11:0] smp_data = '0;
    logic smp_ready;
    logic usb_valid, uart_valid;
    logic usb_ready = 1'b1, uart_ready = 1'b1;
    logic [7:0] usb_byte, uart_byte;

    int checks = 0, fails = 0;
    int mode_usb = 0, mode_uart = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] exp_q [2][0:255];
    int wr [2] = '{0, 0};
    int rd [2] = '{0, 0};
    bit held_v [2] = '{0, 0};
    logic [7:0] held_b [2];
    bit finished = 0;

    always #2.5 clk = ~clk;

    samp_packetizer dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_analog(smp_analog), .smp_chan(smp_chan), .smp_data(smp_data),
        .link_sel(link_sel), .usb_valid(usb_valid), .usb_ready(usb_ready),
        .usb_byte(usb_byte), .uart_valid(uart_valid), .uart_ready(uart_ready),
        .uart_byte(uart_byte)
    );

    task automatic chk(bit ok, string req, logic [15:0] got, logic [15:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, expv, $time);
        end
    endtask

    function automatic logic pick(int mode, logic bitv);
        return (mode == 0) ? 1'b1 : (mode == 1) ? bitv : 1'b0;
    endfunction

    // Per-link observation: hold rule, routing and byte contents.
    task automatic watch(int l, logic v, logic r, logic [7:0] b);
        if (held_v[l]) chk(v && b == held_b[l], "R6", {7'd0, v, b}, {8'd1, held_b[l]});
        held_v[l] = v && !r;
        held_b[l] = b;
        if (v && r) begin
            if (rd[l] == wr[l]) begin
                chk(1'b0, "R7", {8'd0, b}, 16'hFFFF);
            end else begin
                logic [7:0] e;
                e = exp_q[l][rd[l] % 256];
                rd[l]++;
                if (e[7:4] == 4'hF) chk(b == e, "R3", {8'd0, b}, {8'd0, e});
                else begin
                    chk(b == e, "R1", {8'd0, b}, {8'd0, e});
                    chk(b[7:4] != 4'hF, "R4", {8'd0, b}, {8'd0, e});
                end
            end
        end
    endtask

    // Drive readies on falling edges, then observe just after.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        usb_ready = pick(mode_usb, lfsr[0]);
        uart_ready = pick(mode_uart, lfsr[3]);
        #1;
        if (rst_n) begin
            watch(0, usb_valid, usb_ready, usb_byte);
            watch(1, uart_valid, uart_ready, uart_byte);
        end
    end

    task automatic push(int l, logic [7:0] b);
        exp_q[l][wr[l] % 256] = b;
        wr[l]++;
    endtask

    task automatic send(bit an, logic [3:0] ch, logic [11:0] d, bit lk);
        int l;
        l = lk ? 1 : 0;
        if (an) push(l, {4'hF, ch});
        for (int k = 0; k < 3; k++) push(l, {an, 3'(k), d[(2-k)*4 +: 4]});
        @(negedge clk);
        smp_valid = 1'b1; smp_analog = an; smp_chan = ch; smp_data = d; link_sel = lk;
        #2;
        while (!smp_ready) begin @(negedge clk); #2; end
        @(negedge clk);
        smp_valid = 1'b0;
        #2;
        chk(!smp_ready, "R5", {15'd0, smp_ready}, 16'd0);
    endtask

    task automatic drain(string req);
        int n;
        n = 0;
        while ((rd[0] != wr[0] || rd[1] != wr[1] || !smp_ready) && n < 2000) begin
            @(negedge clk); #2; n++;
        end
        chk(n < 2000, req, 16'(rd[0] + rd[1]), 16'(wr[0] + wr[1]));
    endtask

    task automatic t_reset();
        #2;
        chk(smp_ready == 1'b1, "R9", {15'd0, smp_ready}, 16'd1);
        chk(!usb_valid && !uart_valid, "R9", {14'd0, usb_valid, uart_valid}, 16'd0);
    endtask

    task automatic t_digital();
        mode_usb = 0; mode_uart = 0;
        send(1'b0, 4'h9, 12'hA5C, 1'b0);   // R3 channel ignored, no marker
        drain("R2");
    endtask

    task automatic t_analog();
        send(1'b1, 4'h0, 12'hFFF, 1'b0);   // R4 all-ones payload
        send(1'b1, 4'hF, 12'h123, 1'b0);   // R3 top channel
        drain("R3");
    endtask

    task automatic t_uart_bp();
        mode_uart = 1; mode_usb = 2;        // R7 USB ready ignored
        send(1'b1, 4'h7, 12'h3C9, 1'b1);
        send(1'b0, 4'h2, 12'hFFF, 1'b1);   // R5 second waits
        send(1'b1, 4'hA, 12'h0F0, 1'b1);
        drain("R6");
        mode_usb = 0; mode_uart = 0;
    endtask

    task automatic t_sel_change();
        mode_uart = 2;
        send(1'b1, 4'h3, 12'h8E4, 1'b1);
        @(negedge clk); link_sel = 1'b0;
        repeat (5) @(negedge clk);
        #2;
        chk(!usb_valid && uart_valid, "R8", {14'd0, usb_valid, uart_valid}, 16'd1);
        mode_uart = 0;
        drain("R8");
    endtask

    task automatic t_reset_mid();
        mode_usb = 2;
        send(1'b1, 4'h5, 12'h456, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rd[0] = wr[0]; rd[1] = wr[1];
        held_v[0] = 0; held_v[1] = 0;
        rst_n = 1'b1;
        #2;
        chk(smp_ready && !usb_valid && !uart_valid, "R9",
            {13'd0, smp_ready, usb_valid, uart_valid}, 16'd4);
        mode_usb = 0;
        send(1'b0, 4'h0, 12'h7E1, 1'b0);   // R9 restarts at index 0
        drain("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_digital();
        t_analog();
        t_uart_bp();
        t_sel_change();
        t_reset_mid();
        repeat (5) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule